// File: doc/BRIEF.md
# Sliding-Window Pairwise Product Accumulator

The block keeps an array of `N` signed 32-bit words. A host fills it through a plain write port while the block is idle. A single-cycle `start` pulse then launches a pipelined loop. Iteration `i` runs from 0 through `N-4` and takes the four neighbouring words at indices `i`, `i+1`, `i+2` and `i+3`. It multiplies the first pair and the second pair at 64-bit width and adds both products into a 64-bit running total. When the last iteration has left the multiply-add pipeline, `done` pulses for one cycle. The final total is then on `sum`, and the number of clock edges the run took is on `cycles`.

The elaboration parameter `PARTITION` picks how the words are stored. With `PARTITION = 0` the words sit in one memory with two read ports. The four reads of an iteration are then split across two cycles, so a new iteration starts every second cycle. With `PARTITION = 1` every word is its own register, and a run-time index selects the four words. All four reads happen in one cycle, so a new iteration starts every cycle. Both choices produce the same total. Only the run length differs.

Top module: `win_prod_acc`

## Requirements
- R1: While `busy` is low, a cycle with `wr_en` high stores `wr_data` at word address `wr_addr`. A later run uses the new value.
- R2: A `start` pulse while idle clears the total and begins a run. `busy` is high from the next clock edge onward.
- R3: After a run, `sum` equals the sum over i = 0..N-4 of a[i]*a[i+1] + a[i+2]*a[i+3]. Each product is formed from sign-extended 32-bit operands at 64-bit width.
- R4: The total wraps modulo 2^64, with no saturation and no flag.
- R5: `done` is high for exactly one cycle per run. In that same cycle `busy` is already low and `sum` holds the final total.
- R6: With `PARTITION = 1`, `cycles` reads N after a run: N-3 issue edges plus three pipeline edges.
- R7: With `PARTITION = 0`, `cycles` reads 2N-4 after a run: two edges per iteration plus two pipeline edges.
- R8: Write-port activity while `busy` is high has no effect on the stored words.
- R9: A `start` pulse while `busy` is high is ignored. The run's total and cycle count are unchanged.
- R10: After reset, `busy`, `done`, `sum` and `cycles` are all zero.
- R11: While idle and with no `start`, `sum` and `cycles` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe of the load port |
| wr_addr | input | $clog2(N) | Word address of the load port |
| wr_data | input | DW | Word to store (two's complement) |
| start | input | 1 | One-cycle pulse that launches a run |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| sum | output | 2*DW | Accumulated total (two's complement) |
| cycles | output | CW | Clock edges from start to done |

## Verification
The bench drives one partitioned instance and one RAM-style instance from the same inputs, so every test compares the two storage styles on identical data.

The data patterns each target a different fault:
- All-ones data exposes a wrong iteration count.
- A rising ramp exposes swapped or shifted element indices, because each window gives a different product.
- Mixed-sign values test the sign extension of the products.
- Data at the most negative and most positive 32-bit values forces the 64-bit total to wrap.

Directed runs then cover the remaining cases:
- Overwriting a single word shows that the load port reaches the intended address.
- Injecting a write and a second `start` in the middle of a run, then repeating the run, shows that both are ignored.

// File: rtl/win_pkg.sv
package win_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DRAIN = 2'd2
   } win_state_e;

   // Edges spent in the drain state before done, per storage style.
   function automatic int unsigned drain_edges(input bit part);
      return part ? 32'd2 : 32'd1;
   endfunction

endpackage

// File: rtl/win_store.sv
module win_store #(
   parameter int unsigned N    = 8,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 3,
   parameter bit          PART = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [AW-1:0]        waddr,
   input  logic [DW-1:0]        wdata,
   input  logic                 iss,
   input  logic [AW-1:0]        idx,
   output logic signed [DW-1:0] q0,
   output logic signed [DW-1:0] q1,
   output logic signed [DW-1:0] q2,
   output logic signed [DW-1:0] q3,
   output logic                 q_vld
);

   logic [DW-1:0] mem [N];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (PART) begin : g_part
      // Every word is a register: four run-time selected reads in one cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_vld <= 1'b0;
            q0    <= '0;
            q1    <= '0;
            q2    <= '0;
            q3    <= '0;
         end else begin
            q_vld <= iss;
            if (iss) begin
               q0 <= mem[idx];
               q1 <= mem[idx + AW'(1)];
               q2 <= mem[idx + AW'(2)];
               q3 <= mem[idx + AW'(3)];
            end
         end
      end
   end else begin : g_ram
      // Two read ports: the first pair is read in phase 0, the second in phase 1.
      logic          ph1;
      logic [AW-1:0] base;
      logic [AW-1:0] ad_a, ad_b;
      logic [DW-1:0] rd_a, rd_b, h0, h1;

      always_comb begin
         ad_a = ph1 ? base + AW'(2) : idx;
         ad_b = ph1 ? base + AW'(3) : idx + AW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph1   <= 1'b0;
            q_vld <= 1'b0;
         end else begin
            ph1   <= iss;
            q_vld <= ph1;
         end
      end

      always_ff @(posedge clk) begin
         if (iss) base <= idx;
         if (iss || ph1) begin
            rd_a <= mem[ad_a];
            rd_b <= mem[ad_b];
         end
         if (ph1) begin
            h0 <= rd_a;
            h1 <= rd_b;
         end
      end

      assign q0 = h0;
      assign q1 = h1;
      assign q2 = rd_a;
      assign q3 = rd_b;
   end

endmodule

// File: rtl/win_mac.sv
module win_mac #(
   parameter int unsigned DW = 32,
   localparam int unsigned PW = 2 * DW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 in_vld,
   input  logic signed [DW-1:0] a0,
   input  logic signed [DW-1:0] a1,
   input  logic signed [DW-1:0] b0,
   input  logic signed [DW-1:0] b1,
   output logic [PW-1:0]        acc
);

   logic signed [PW-1:0] pa, pb;
   logic                 p_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa    <= '0;
         pb    <= '0;
         p_vld <= 1'b0;
         acc   <= '0;
      end else begin
         p_vld <= in_vld;
         if (in_vld) begin
            pa <= PW'(a0) * PW'(a1);
            pb <= PW'(b0) * PW'(b1);
         end
         if (clr)        acc <= '0;
         else if (p_vld) acc <= acc + pa + pb;
      end
   end

endmodule

// File: rtl/win_prod_acc.sv
module win_prod_acc
   import win_pkg::*;
#(
   parameter int unsigned N         = 8,
   parameter int unsigned DW        = 32,
   parameter int unsigned CW        = 16,
   parameter bit          PARTITION = 1'b1,
   localparam int unsigned AW       = (N > 1) ? $clog2(N) : 1,
   localparam int unsigned PW       = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic [PW-1:0] sum,
   output logic [CW-1:0] cycles
);

   localparam int unsigned LAST    = N - 4;
   localparam int unsigned DR_LAST = drain_edges(PARTITION);

   if (N < 4) begin : g_chk_n
      $error("win_prod_acc: N must be at least 4");
   end
   if (DW < 2) begin : g_chk_dw
      $error("win_prod_acc: DW must be at least 2");
   end
   if (CW < 4) begin : g_chk_cw
      $error("win_prod_acc: CW too narrow");
   end

   win_state_e    state;
   logic [AW-1:0] idx;
   logic          phase;
   logic [1:0]    dr;
   logic [CW-1:0] cnt;
   logic          iss, clr, we;
   logic signed [DW-1:0] q0, q1, q2, q3;
   logic          q_vld;

   assign busy = (state != ST_IDLE);
   assign clr  = (state == ST_IDLE) && start;
   assign iss  = (state == ST_ISSUE) && (PARTITION || !phase);
   assign we   = wr_en && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
         phase <= 1'b0;
         dr    <= '0;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_ISSUE;
                  idx   <= '0;
                  phase <= 1'b0;
                  cnt   <= '0;
               end
            end
            ST_ISSUE: begin
               cnt <= cnt + CW'(1);
               if (!PARTITION) phase <= !phase;
               if (PARTITION || phase) begin
                  if (idx == AW'(LAST)) begin
                     state <= ST_DRAIN;
                     dr    <= '0;
                  end else begin
                     idx <= idx + AW'(1);
                  end
               end
            end
            ST_DRAIN: begin
               cnt <= cnt + CW'(1);
               dr  <= dr + 2'd1;
               if (dr == 2'(DR_LAST)) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cycles = cnt;

   win_store #(.N(N), .DW(DW), .AW(AW), .PART(PARTITION)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .waddr (wr_addr),
      .wdata (wr_data),
      .iss   (iss),
      .idx   (idx),
      .q0    (q0),
      .q1    (q1),
      .q2    (q2),
      .q3    (q3),
      .q_vld (q_vld)
   );

   win_mac #(.DW(DW)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .in_vld (q_vld),
      .a0     (q0),
      .a1     (q1),
      .b0     (q2),
      .b1     (q3),
      .acc    (sum)
   );

endmodule

// File: rtl/win_prod_acc_chk.sv
module win_prod_acc_chk #(
   parameter int unsigned PW = 64,
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [PW-1:0] sum,
   input logic [CW-1:0] cycles
);

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r11_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(sum));

   a_r11_cycles_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(cycles));

   // R6 and R7: the counter advances by one on every edge of a run
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (cycles == $past(cycles) + CW'(1)));

endmodule

bind win_prod_acc win_prod_acc_chk #(.PW(PW), .CW(CW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .sum    (sum),
   .cycles (cycles)
);

// File: tb/win_prod_acc_test.sv
`timescale 1ns/1ps
module win_prod_acc_test;

   localparam int N  = 8;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int AW = $clog2(N);
   localparam int NV = 5;

   localparam int VEC [NV][N] = '{
      '{1, 1, 1, 1, 1, 1, 1, 1},
      '{1, 2, 3, 4, 5, 6, 7, 8},
      '{-3, 7, -11, 2, 100000, -50000, 9, -1},
      '{32'sh80000000, 32'sh80000000, 32'sh80000000, 32'sh80000000,
        32'sh80000000, 32'sh80000000, 32'sh80000000, 32'sh80000000},
      '{32'sh7fffffff, -1, 32'sh7fffffff, 32'sh7fffffff,
        32'sh80000000, 32'sh7fffffff, 32'sh80000000, 5}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          start = 1'b0;
   logic          busy_p, done_p, busy_r, done_r;
   logic [63:0]   sum_p, sum_r;
   logic [CW-1:0] cyc_p, cyc_r;

   int tests = 0;
   int fails = 0;
   int cur [N];

   always #4 clk = ~clk;

   win_prod_acc #(.N(N), .DW(DW), .CW(CW), .PARTITION(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .busy(busy_p), .done(done_p),
      .sum(sum_p), .cycles(cyc_p));

   win_prod_acc #(.N(N), .DW(DW), .CW(CW), .PARTITION(1'b0)) uut_ram (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .start(start), .busy(busy_r), .done(done_r),
      .sum(sum_r), .cycles(cyc_r));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint model_sum();
      longint s = 0;
      for (int i = 0; i <= N - 4; i++)
         s += longint'(cur[i]) * longint'(cur[i+1]) + longint'(cur[i+2]) * longint'(cur[i+3]);
      return s;
   endfunction

   task automatic write_word(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      cur[a] = d;
   endtask

   task automatic run(input bit inj, input string req);
      longint exp;
      logic [63:0] sp, sr;
      int dp, dr;
      exp = model_sum();
      dp = 0; dr = 0; sp = '0; sr = '0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      check(busy_p && busy_r, "R2 busy after start", longint'({busy_p, busy_r}), 3);
      for (int k = 0; k < 100; k++) begin
         if (done_p) begin dp++; sp = sum_p; check(!busy_p, "R5 busy low at done", 1, 0); end
         if (done_r) begin dr++; sr = sum_r; check(!busy_r, "R5 busy low at done", 1, 0); end
         if (!busy_p && !busy_r) break;
         if (inj && k == 1) begin
            wr_en = 1'b1; wr_addr = '0; wr_data = 32'd12345; start = 1'b1;
         end else begin
            wr_en = 1'b0; start = 1'b0;
         end
         @(negedge clk);
      end
      wr_en = 1'b0; start = 1'b0;
      check(dp == 1, "R5 done pulses (partitioned)", dp, 1);
      check(dr == 1, "R5 done pulses (ram)", dr, 1);
      check(sp == exp, {req, " sum at done (partitioned)"}, longint'(sp), exp);
      check(sr == exp, {req, " sum at done (ram)"}, longint'(sr), exp);
      check(cyc_p == CW'(N), inj ? "R9 R6 cycles (partitioned)" : "R6 cycles (partitioned)",
            longint'(cyc_p), N);
      check(cyc_r == CW'(2*N-4), inj ? "R9 R7 cycles (ram)" : "R7 cycles (ram)",
            longint'(cyc_r), 2*N-4);
      repeat (3) @(negedge clk);
      check(sum_p == exp && sum_r == exp, "R11 sum held", longint'(sum_r), exp);
      check(cyc_p == CW'(N) && cyc_r == CW'(2*N-4), "R11 cycles held", longint'(cyc_p), N);
   endtask

   initial begin
      #(8.0 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy_p && !busy_r && !done_p && !done_r, "R10 flags in reset", 1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sum_p == 0 && sum_r == 0, "R10 sum after reset", longint'(sum_p | sum_r), 0);
      check(cyc_p == 0 && cyc_r == 0, "R10 cycles after reset", longint'(cyc_p | cyc_r), 0);

      // R1 R3 table walk
      for (int v = 0; v < NV; v++) begin
         for (int i = 0; i < N; i++) write_word(i, VEC[v][i]);
         run(1'b0, (v >= 3) ? "R4" : "R3");
      end

      // R1: single word overwrite changes the next result
      write_word(3, -7);
      run(1'b0, "R1");

      // R8 R9: write and start injected mid-run, then a repeat run on the same data
      run(1'b1, "R8");
      run(1'b0, "R8 repeat");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule